// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a 4 KB window of 32-bit control words on a simple word-addressed bus. Every access carries a strobe, a write flag, a 10-bit word address and 32 bits of write data. Each word offset belongs to one access class: read-write, read-only, write-only or unmapped. A write to a read-only or unmapped word is dropped. A read of a write-only or unmapped word still returns the stored word. Both kinds of access raise a one-cycle error pulse.

A single protection flag guards the ordinary control words. The flag comes out of reset set. Software clears it by writing a 16-bit magic value to a dedicated write-only word, and sets it again the same way through a second key word. While the flag is set, the one-bit word at offset 0x000 and the two key words still respond, and all other writes are silently discarded.

An unlocked write to the reset-control word with bit 0 high produces a one-cycle system reset request. Non-writable words are constants tied to their reset value, so only writable offsets cost flops.

Top module: `keyed_ctrl_bank`

## Requirements
- R1: A write to byte offset 0x004 whose bits [15:0] equal 0x767B sets the protection flag. Any other data written there leaves the flag unchanged.
- R2: A write to byte offset 0x008 whose bits [15:0] equal 0xDF0D clears the protection flag. Any other data written there leaves the flag unchanged.
- R3: A read of byte offset 0x00C returns the protection flag in bit 0 and zeros above it. After reset the value is 1. Writes to this offset are dropped.
- R4: While the flag is set, writes to every read-write or write-only offset other than 0x000 are discarded. Offset 0x000 and the two key offsets keep working.
- R5: Offset 0x000 stores only bit 0 of the write data, and bits [31:1] read as zero.
- R6: The write-only offsets are 0x004, 0x008, 0x60C and 0x614. The read-only offsets are 0x00C, 0x10C, 0x17C, 0x18C, 0x19C, 0x1AC, 0x25C, 0x530, 0x618 and 0x620. A write to a read-only or unmapped offset never changes stored data.
- R7: `acc_err` is high for exactly the one cycle after an illegal access. An illegal access is a write to a read-only or unmapped offset, or a read of a write-only or unmapped offset. Legal accesses, including writes dropped by the lock, leave it low.
- R8: An unlocked write to offset 0x200 with bit 0 high drives `sys_rst_req` high for the one cycle after the write. A locked write there produces no pulse.
- R9: Reset values: 0x0001A008 at 0x100, 0x104 and 0x108; 0x0000003F at 0x10C; 0x00003F03 at 0x154; 0x00010000 at 0x17C, 0x18C, 0x19C and 0x1AC; 0x00000001 at 0x25C. The other read-only offsets, the key offsets and all unmapped offsets read zero.
- R10: Read data is registered and valid in the cycle after the read request. It returns the stored word for every offset, including flagged reads, and holds its value until the next read.
- R11: An unlocked write to a read-write or write-only offset other than 0x000 stores all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| acc_err | output | 1 | Illegal-access pulse, cycle after the access |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
A wrong protection flag shows up one cycle after the next read of offset 0x00C. It also shows as a written word that reads back unchanged, or changed when it should not have. A misclassified offset shows as an `acc_err` value that is wrong in the cycle right after the access. It can also show as stored data that changes on a read-only or unmapped word. The sweeps write a unique pattern to every one of the 1024 offsets, once unlocked and once locked, and then read all of them back. Each flag, class or storage fault therefore appears within one pass of the sweep.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int ADDR_W  = 10;
  localparam int DATA_W  = 32;
  localparam int KEY_W   = 16;

  localparam logic [KEY_W-1:0] LOCK_KEY   = 16'h767B;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D;

  localparam logic [ADDR_W-1:0] W_SCRATCH = 10'h000;
  localparam logic [ADDR_W-1:0] W_LOCK    = 10'h001;
  localparam logic [ADDR_W-1:0] W_UNLOCK  = 10'h002;
  localparam logic [ADDR_W-1:0] W_STATUS  = 10'h003;
  localparam logic [ADDR_W-1:0] W_SWRST   = 10'h080;

  typedef enum logic [1:0] {
    ACC_RW   = 2'd0,
    ACC_RO   = 2'd1,
    ACC_WO   = 2'd2,
    ACC_NONE = 2'd3
  } acc_cls_e;

  function automatic logic [11:0] byte_of(input logic [ADDR_W-1:0] w);
    return {w, 2'b00};
  endfunction

  function automatic acc_cls_e word_class(input logic [ADDR_W-1:0] w);
    logic [11:0] b;
    b = byte_of(w);
    if (b inside {12'h004, 12'h008, 12'h60C, 12'h614})
      return ACC_WO;
    if (b inside {12'h00C, 12'h10C, 12'h17C, 12'h18C, 12'h19C, 12'h1AC,
                  12'h25C, 12'h530, 12'h618, 12'h620})
      return ACC_RO;
    if (b inside {12'h000, [12'h100:12'h108], [12'h110:12'h16C],
                  [12'h170:12'h178], [12'h180:12'h188], [12'h190:12'h198],
                  [12'h1A0:12'h1A8], 12'h1B8, 12'h1C0, 12'h1C4,
                  [12'h200:12'h244], 12'h24C, 12'h250, 12'h258,
                  12'h300, 12'h304, [12'h440:12'h448], 12'h600, 12'h61C,
                  [12'h700:12'h7D4], [12'h804:12'h80C], 12'h830, 12'h834,
                  12'h900, 12'h910, 12'hA00, 12'hA30, 12'hA50,
                  [12'hA60:12'hA8C], 12'hA90, 12'hAA0, 12'hAB0,
                  [12'hB00:12'hB0C], 12'hB14, 12'hB18, [12'hB40:12'hB74]})
      return ACC_RW;
    return ACC_NONE;
  endfunction

  function automatic logic [DATA_W-1:0] reset_word(input logic [ADDR_W-1:0] w);
    logic [11:0] b;
    b = byte_of(w);
    if (b inside {[12'h100:12'h108]})                     return 32'h0001_A008;
    if (b == 12'h10C)                                     return 32'h0000_003F;
    if (b inside {[12'h110:12'h118]})                     return 32'h0001_4000;
    if (b == 12'h154)                                     return 32'h0000_3F03;
    if (b inside {12'h17C, 12'h18C, 12'h19C, 12'h1AC})    return 32'h0001_0000;
    if (b == 12'h250)                                     return 32'h0000_0040;
    if (b == 12'h25C)                                     return 32'h0000_0001;
    if (b inside {[12'h708:12'h720]})                     return 32'h0000_0601;
    if (b inside {[12'h700:12'h7D4]})                     return 32'h0000_1601;
    if (b inside {12'h808, 12'h80C})                      return 32'hFFFF_FFFF;
    return '0;
  endfunction

endpackage

// File: rtl/bank_access_decode.sv
module bank_access_decode
  import sysctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output acc_cls_e          cls,
  output logic              is_key
);
  always_comb begin
    cls    = word_class(addr);
    is_key = (addr == W_LOCK) || (addr == W_UNLOCK);
  end
endmodule

// File: rtl/bank_lock_ctrl.sv
module bank_lock_ctrl
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [KEY_W-1:0]  key_data,
  output logic              lock_q
);
  logic set_hit, clr_hit;

  always_comb begin
    set_hit = wr_stb && (addr == W_LOCK)   && (key_data == LOCK_KEY);
    clr_hit = wr_stb && (addr == W_UNLOCK) && (key_data == UNLOCK_KEY);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       lock_q <= 1'b1;
    else if (set_hit) lock_q <= 1'b1;
    else if (clr_hit) lock_q <= 1'b0;
  end
endmodule

// File: rtl/bank_reg_store.sv
module bank_reg_store
  import sysctl_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          lock_q,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] words [DEPTH];
  logic [DW-1:0] wval;

  always_comb begin
    wval = (addr == AW'(W_SCRATCH)) ? {{(DW-1){1'b0}}, wdata[0]} : wdata;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam acc_cls_e CLS = word_class(ADDR_W'(g));
    localparam logic [DW-1:0] RV = DW'(reset_word(ADDR_W'(g)));
    if ((CLS == ACC_RW || CLS == ACC_WO) && g != int'(W_LOCK) && g != int'(W_UNLOCK)) begin : g_ff
      always_ff @(posedge clk) begin
        if (!rst_n)                        words[g] <= RV;
        else if (we && addr == AW'(g))     words[g] <= wval;
      end
    end else begin : g_const
      assign words[g] = RV;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= (addr == AW'(W_STATUS)) ? {{(DW-1){1'b0}}, lock_q} : words[addr];
  end
endmodule

// File: rtl/keyed_ctrl_bank.sv
module keyed_ctrl_bank
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              acc_err,
  output logic              sys_rst_req
);
  acc_cls_e acc_cls;
  logic     is_key;
  logic     lock_q;
  logic     wr_stb, rd_stb;
  logic     store_we;
  logic     illegal;
  logic     swrst_hit;

  bank_access_decode u_dec (
    .addr   (req_addr),
    .cls    (acc_cls),
    .is_key (is_key)
  );

  always_comb begin
    wr_stb    = req_valid && req_write;
    rd_stb    = req_valid && !req_write;
    store_we  = wr_stb && !is_key && (acc_cls == ACC_RW || acc_cls == ACC_WO)
                && (!lock_q || req_addr == W_SCRATCH);
    illegal   = (wr_stb && (acc_cls == ACC_RO || acc_cls == ACC_NONE)) ||
                (rd_stb && (acc_cls == ACC_WO || acc_cls == ACC_NONE));
    swrst_hit = store_we && (req_addr == W_SWRST) && req_wdata[0];
  end

  bank_lock_ctrl u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .addr     (req_addr),
    .key_data (req_wdata[KEY_W-1:0]),
    .lock_q   (lock_q)
  );

  bank_reg_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (store_we),
    .rd     (rd_stb),
    .addr   (req_addr),
    .wdata  (req_wdata),
    .lock_q (lock_q),
    .rdata  (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_err     <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      acc_err     <= illegal;
      sys_rst_req <= swrst_hit;
    end
  end
endmodule

// File: rtl/bank_ctrl_chk.sv
module bank_ctrl_chk
  import sysctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              lock_q,
  input logic              store_we,
  input acc_cls_e          acc_cls,
  input logic              acc_err,
  input logic              sys_rst_req
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  lock_key_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == W_LOCK && req_wdata[15:0] == LOCK_KEY) |=> lock_q);

  // R2
  unlock_key_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == W_UNLOCK && req_wdata[15:0] == UNLOCK_KEY) |=> !lock_q);

  // R3
  lock_moves_only_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && lock_q != $past(lock_q)) |->
      $past(req_valid && req_write && (req_addr == W_LOCK || req_addr == W_UNLOCK)));

  // R4
  locked_store_only_scratch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_we && lock_q) |-> (req_addr == W_SCRATCH));

  // R6
  store_only_writable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_we |-> (acc_cls == ACC_RW || acc_cls == ACC_WO));

  // R7
  err_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && acc_err) |-> $past(req_valid));

  // R8
  swrst_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && sys_rst_req) |->
      $past(req_valid && req_write && req_addr == W_SWRST && req_wdata[0] && !lock_q));
endmodule

bind keyed_ctrl_bank bank_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .lock_q      (lock_q),
  .store_we    (store_we),
  .acc_cls     (acc_cls),
  .acc_err     (acc_err),
  .sys_rst_req (sys_rst_req)
);

// File: tb/keyed_ctrl_bank_bench.sv
`timescale 1ns/1ps
module keyed_ctrl_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        acc_err;
  logic        sys_rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyed_ctrl_bank u_keyed_ctrl_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .acc_err(acc_err), .sys_rst_req(sys_rst_req)
  );

  // 0 = read-write, 1 = read-only, 2 = write-only, 3 = unmapped (from R6 and the map)
  function automatic int cls_of(input int w);
    int b;
    b = w * 4;
    if (b == 'h004 || b == 'h008 || b == 'h60C || b == 'h614) return 2;
    if (b == 'h00C || b == 'h10C || b == 'h25C || b == 'h530 || b == 'h618 || b == 'h620) return 1;
    if (b >= 'h17C && b <= 'h1AC && (b % 16) == 'hC) return 1;
    if (b == 0) return 0;
    if ((b >= 'h100 && b <= 'h108) || (b >= 'h110 && b <= 'h16C)) return 0;
    if (b >= 'h170 && b <= 'h1A8 && (b % 16) != 'hC) return 0;
    if (b == 'h1B8 || b == 'h1C0 || b == 'h1C4 || b == 'h24C || b == 'h250 || b == 'h258) return 0;
    if (b >= 'h200 && b <= 'h244) return 0;
    if (b == 'h300 || b == 'h304 || (b >= 'h440 && b <= 'h448) || b == 'h600 || b == 'h61C) return 0;
    if ((b >= 'h700 && b <= 'h7D4) || (b >= 'h804 && b <= 'h80C)) return 0;
    if (b == 'h830 || b == 'h834 || b == 'h900 || b == 'h910) return 0;
    if (b == 'hA00 || b == 'hA30 || b == 'hA50 || b == 'hA90 || b == 'hAA0 || b == 'hAB0) return 0;
    if (b >= 'hA60 && b <= 'hA8C) return 0;
    if ((b >= 'hB00 && b <= 'hB0C) || b == 'hB14 || b == 'hB18) return 0;
    if (b >= 'hB40 && b <= 'hB74) return 0;
    return 3;
  endfunction

  // read-only reset values from R9
  function automatic logic [31:0] ro_val(input int w);
    int b;
    b = w * 4;
    if (b == 'h10C) return 32'h3F;
    if (b == 'h25C) return 32'h1;
    if (b == 'h17C || b == 'h18C || b == 'h19C || b == 'h1AC) return 32'h0001_0000;
    return 32'h0;
  endfunction

  function automatic logic [31:0] pat(input int w);
    logic [9:0] a;
    a = 10'(w);
    return {6'h2A, a, 6'h15, a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int w, input logic [31:0] d, output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 10'(w); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    err = acc_err;
  endtask

  task automatic rd(input int w, output logic [31:0] d, output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 10'(w);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    err = acc_err;
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic e;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(acc_err == 0 && sys_rst_req == 0, "R7 reset outputs", {30'b0, acc_err, sys_rst_req}, 0);

    // reset state: locked, reset values
    rd(3, d, e); check(d == 32'h1, "R3 lock after reset", d, 32'h1);
    rd('h40, d, e); check(d == 32'h0001_A008, "R9 0x100", d, 32'h0001_A008);
    rd('h41, d, e); check(d == 32'h0001_A008, "R9 0x104", d, 32'h0001_A008);
    rd('h42, d, e); check(d == 32'h0001_A008, "R9 0x108", d, 32'h0001_A008);
    rd('h55, d, e); check(d == 32'h0000_3F03, "R9 0x154", d, 32'h0000_3F03);
    // R10 hold between reads
    repeat (3) @(negedge clk);
    check(rsp_rdata == 32'h0000_3F03, "R10 read data held", rsp_rdata, 32'h0000_3F03);

    // locked write dropped, scratch still writable with bit 0 only
    wr('h55, 32'h1234_5678, e); check(e == 0, "R7 locked write no flag", {31'b0, e}, 0);
    rd('h55, d, e); check(d == 32'h0000_3F03, "R4 locked write dropped", d, 32'h0000_3F03);
    wr(0, 32'hFFFF_FFFF, e);
    rd(0, d, e); check(d == 32'h1, "R5 scratch bit0 while locked", d, 32'h1);
    // R8 locked reset-control write: no pulse
    wr('h80, 32'h1, e); check(sys_rst_req == 0, "R8 locked no pulse", {31'b0, sys_rst_req}, 0);

    // wrong unlock key ignored
    wr(2, 32'h0000_DF0C, e); rd(3, d, e); check(d == 32'h1, "R2 wrong key ignored", d, 32'h1);
    wr(2, 32'hABCD_DF0D, e); check(e == 0, "R7 key write legal", {31'b0, e}, 0);
    rd(3, d, e); check(d == 32'h0, "R2 unlock", d, 32'h0);
    wr(1, 32'h0000_767A, e); rd(3, d, e); check(d == 32'h0, "R1 wrong key ignored", d, 32'h0);
    wr(3, 32'hFFFF_FFFF, e); check(e == 1, "R7 read-only write flagged", {31'b0, e}, 1);
    rd(3, d, e); check(d == 32'h0, "R3 status write dropped", d, 32'h0);

    // R8 unlocked pulse: one cycle wide, in the cycle after the write
    wr('h80, 32'h1, e); check(sys_rst_req == 1, "R8 pulse", {31'b0, sys_rst_req}, 1);
    @(negedge clk); check(sys_rst_req == 0, "R8 pulse width", {31'b0, sys_rst_req}, 0);
    // R7 pulse width
    rd('h3FF, d, e); check(e == 1, "R7 unmapped read flagged", {31'b0, e}, 1);
    @(negedge clk); check(acc_err == 0, "R7 pulse width", {31'b0, acc_err}, 0);

    // unlocked sweep: write all offsets
    for (int w = 0; w < 1024; w++) begin
      int c;
      c = cls_of(w);
      wr(w, pat(w), e);
      check(e == (c == 1 || c == 3), $sformatf("R6 R7 write flag w=%0h", w), {31'b0, e}, {31'b0, (c == 1 || c == 3)});
    end
    for (int w = 0; w < 1024; w++) begin
      int c;
      logic [31:0] x;
      c = cls_of(w);
      if (w == 0) x = 32'h0;
      else if (w == 1 || w == 2 || w == 3) x = 32'h0;
      else if (c == 0 || c == 2) x = pat(w);
      else if (c == 1) x = ro_val(w);
      else x = 32'h0;
      rd(w, d, e);
      check(d == x, $sformatf("R11 R9 R10 readback w=%0h", w), d, x);
      check(e == (c == 2 || c == 3), $sformatf("R7 read flag w=%0h", w), {31'b0, e}, {31'b0, (c == 2 || c == 3)});
    end

    // relock and sweep again with inverted data
    wr(1, 32'h0000_767B, e);
    rd(3, d, e); check(d == 32'h1, "R1 relock", d, 32'h1);
    for (int w = 0; w < 1024; w++) begin
      if (w != 2) wr(w, ~pat(w), e);
    end
    for (int w = 0; w < 1024; w++) begin
      int c;
      logic [31:0] x;
      c = cls_of(w);
      if (w == 0) x = 32'h1;
      else if (w == 3) x = 32'h1;
      else if (w == 1 || w == 2) x = 32'h0;
      else if (c == 0 || c == 2) x = pat(w);
      else if (c == 1) x = ro_val(w);
      else x = 32'h0;
      rd(w, d, e);
      check(d == x, $sformatf("R4 locked readback w=%0h", w), d, x);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule